// File: doc/BRIEF.md
# Serial Port Register and Interrupt Unit

This block is the bus-side register file of a serial port. A host issues single-word accesses into a 4 KB window. The block decodes the word index, holds the configuration registers and returns their values. It builds a flag word from the transmit and receive FIFO status. It keeps a raw interrupt status word, a mask and a write-one-to-clear path, and it drives one level-sensitive interrupt line. The top of the window holds a table of eight identification bytes. A parameter selects one of two byte sets.

A write to the data word sends the low byte to the transmitter as a one-cycle strobe. A read of the data word pops the receive FIFO through a pop/data/count interface and returns the FIFO head. The receive interrupt bit follows FIFO level crossings at a trigger level. The serial bit engine, the baud generator and DMA handshaking sit outside this block.

Access control is a two-state machine. `ST_IDLE` waits for a request. The transition *accept* (IDLE to RESP) fires on `bus_req`: all write and read side effects commit at that edge. `ST_RESP` drives `bus_ack` for one cycle, with the read data, `bus_err` and `tx_valid`. The transition *release* (RESP to IDLE) is unconditional.

Top module: `uart_regif`

## Requirements
- R1: A request seen in `ST_IDLE` produces `bus_ack` high for exactly the next cycle. A request held while `bus_ack` is high is ignored, and no second side effect occurs.
- R2: The configuration words keep only their low bits. These are index 8 (8 bits), index 9 (16 bits), index 10 (6 bits), index 11 (8 bits), index 12 (16 bits), index 13 (6 bits), index 14 (11 bits) and index 18 (3 bits). They reset to zero, except index 12, which resets to 0x300, and index 13, which resets to 0x12.
- R3: The flag word at index 6 holds `tx_empty` in bit 7, receive-full (count equals depth) in bit 6, `tx_full` in bit 5 and receive-empty (count zero) in bit 4. Writes to it are ignored. After reset, with `tx_empty` high and an empty FIFO, it reads 0x90.
- R4: A write to index 0 pulses `tx_valid` in the ack cycle, with `tx_byte` equal to bits 7:0 of the write data. It also sets raw interrupt bit 5.
- R5: A read of index 0 raises `rx_pop` for the request cycle only. The ack carries `rx_data`, zero-extended, as sampled in that cycle.
- R6: Raw interrupt bit 4 sets one cycle after `rx_count` rises from trigger−1 to the trigger level. It clears one cycle after the count falls from the trigger level to trigger−1. The trigger level defaults to 1.
- R7: Index 15 returns the raw status and index 16 returns raw AND mask. `irq` is high exactly when that masked value is nonzero. Writing index 17 clears every raw bit written as one.
- R8: For offsets 0xFE0 to 0xFFC, the read returns identification byte (offset−0xFE0)>>2. Variant 0 gives 0x11,0x10,0x14,0x00,0x0D,0xF0,0x05,0xB1. Variant 1 gives 0x11,0x00,0x18,0x01,0x0D,0xF0,0x05,0xB1.
- R9: A read or write of an undefined index (2–5, 7, 19 up to the table) returns zero, changes nothing, and raises `bus_err` in the ack cycle. Index 1 reads zero without an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset in the window |
| bus_wdata | input | 32 | Write data |
| bus_ack | output | 1 | Access complete, one cycle |
| bus_rdata | output | 32 | Read data, valid with ack |
| bus_err | output | 1 | Undefined index strobe, with ack |
| tx_valid | output | 1 | Transmit byte strobe |
| tx_byte | output | 8 | Transmit byte |
| tx_empty | input | 1 | Transmit FIFO empty |
| tx_full | input | 1 | Transmit FIFO full |
| rx_pop | output | 1 | Receive FIFO pop request |
| rx_data | input | RX_DW | Receive FIFO head |
| rx_count | input | CNT_W | Receive FIFO fill level |
| irq | output | 1 | Level interrupt |

## Verification
The hardest case to reach is the receive interrupt following a level crossing rather than a non-empty flag. The raw bit must set when the FIFO reaches the trigger level and drop only when a pop takes the count back below it. The bench therefore attaches its own receive FIFO model, driven by `rx_pop` and a push task. It fills that model to full, checks the flag word, and then drains it by reads through the register port. Along the way it checks that the raw bit, the masked bit and `irq` move at the crossing cycles and at no others.

// File: rtl/uart_regif_pkg.sv
package uart_regif_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RESP
    } bus_state_e;

    typedef enum logic [4:0] {
        SEL_DATA,
        SEL_ZERO,
        SEL_FLAG,
        SEL_LOWPWR,
        SEL_DIV_INT,
        SEL_DIV_FRAC,
        SEL_LINE,
        SEL_CTRL,
        SEL_LEVEL,
        SEL_MASK,
        SEL_RAW,
        SEL_MASKED,
        SEL_CLEAR,
        SEL_DMA,
        SEL_IDTAB,
        SEL_BAD
    } reg_sel_e;

    localparam int IRQ_W     = 11;
    localparam int LOWPWR_W  = 8;
    localparam int DIV_INT_W = 16;
    localparam int DIV_FRC_W = 6;
    localparam int LINE_W    = 8;
    localparam int CTRL_W    = 16;
    localparam int LEVEL_W   = 6;
    localparam int DMA_W     = 3;

    localparam int IRQ_BIT_TX = 5;
    localparam int IRQ_BIT_RX = 4;

    localparam logic [CTRL_W-1:0]  CTRL_RST  = 16'h0300;
    localparam logic [LEVEL_W-1:0] LEVEL_RST = 6'h12;

    localparam logic [9:0] IDTAB_BASE_IDX = 10'h3F8;

endpackage

// File: rtl/uart_addr_decode.sv
module uart_addr_decode
    import uart_regif_pkg::*;
(
    input  logic [11:0] addr,
    output reg_sel_e    sel,
    output logic [2:0]  id_idx
);
    logic [9:0] word_idx;

    assign word_idx = addr[11:2];
    assign id_idx   = word_idx[2:0];

    always_comb begin
        if (word_idx >= IDTAB_BASE_IDX) begin
            sel = SEL_IDTAB;
        end else begin
            case (word_idx)
                10'd0:   sel = SEL_DATA;
                10'd1:   sel = SEL_ZERO;
                10'd6:   sel = SEL_FLAG;
                10'd8:   sel = SEL_LOWPWR;
                10'd9:   sel = SEL_DIV_INT;
                10'd10:  sel = SEL_DIV_FRAC;
                10'd11:  sel = SEL_LINE;
                10'd12:  sel = SEL_CTRL;
                10'd13:  sel = SEL_LEVEL;
                10'd14:  sel = SEL_MASK;
                10'd15:  sel = SEL_RAW;
                10'd16:  sel = SEL_MASKED;
                10'd17:  sel = SEL_CLEAR;
                10'd18:  sel = SEL_DMA;
                default: sel = SEL_BAD;
            endcase
        end
    end
endmodule

// File: rtl/uart_id_rom.sv
module uart_id_rom #(
    parameter int VARIANT = 0
) (
    input  logic [2:0] idx,
    output logic [7:0] id_byte
);
    generate
        if (VARIANT == 0) begin : g_variant_a
            always_comb begin
                case (idx)
                    3'd0:    id_byte = 8'h11;
                    3'd1:    id_byte = 8'h10;
                    3'd2:    id_byte = 8'h14;
                    3'd3:    id_byte = 8'h00;
                    3'd4:    id_byte = 8'h0D;
                    3'd5:    id_byte = 8'hF0;
                    3'd6:    id_byte = 8'h05;
                    default: id_byte = 8'hB1;
                endcase
            end
        end else begin : g_variant_b
            always_comb begin
                case (idx)
                    3'd0:    id_byte = 8'h11;
                    3'd1:    id_byte = 8'h00;
                    3'd2:    id_byte = 8'h18;
                    3'd3:    id_byte = 8'h01;
                    3'd4:    id_byte = 8'h0D;
                    3'd5:    id_byte = 8'hF0;
                    3'd6:    id_byte = 8'h05;
                    default: id_byte = 8'hB1;
                endcase
            end
        end
    endgenerate
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
    import uart_regif_pkg::*;
#(
    parameter int CNT_W   = 5,
    parameter int RX_TRIG = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_set,
    input  logic             clr_we,
    input  logic [IRQ_W-1:0] clr_bits,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [IRQ_W-1:0] mask,
    output logic [IRQ_W-1:0] raw,
    output logic [IRQ_W-1:0] masked,
    output logic             irq
);
    localparam logic [CNT_W-1:0] TRIG_LVL = CNT_W'(RX_TRIG);
    localparam logic [CNT_W-1:0] TRIG_LOW = CNT_W'(RX_TRIG - 1);

    logic [CNT_W-1:0] count_q;
    logic [IRQ_W-1:0] raw_q, raw_d;
    logic             rx_up, rx_down;

    assign rx_up   = (count_q == TRIG_LOW) && (rx_count == TRIG_LVL);
    assign rx_down = (count_q == TRIG_LVL) && (rx_count == TRIG_LOW);

    always_comb begin
        raw_d = raw_q;
        if (clr_we)  raw_d = raw_d & ~clr_bits;
        if (rx_down) raw_d[IRQ_BIT_RX] = 1'b0;
        if (tx_set)  raw_d[IRQ_BIT_TX] = 1'b1;
        if (rx_up)   raw_d[IRQ_BIT_RX] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raw_q   <= '0;
            count_q <= '0;
        end else begin
            raw_q   <= raw_d;
            count_q <= rx_count;
        end
    end

    assign raw    = raw_q;
    assign masked = raw_q & mask;
    assign irq    = |masked;
endmodule

// File: rtl/uart_regif.sv
module uart_regif
    import uart_regif_pkg::*;
#(
    parameter int ID_VARIANT = 0,
    parameter int RX_DEPTH   = 16,
    parameter int RX_DW      = 12,
    parameter int RX_TRIG    = 1,
    parameter int CNT_W      = $clog2(RX_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_req,
    input  logic             bus_we,
    input  logic [11:0]      bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic             bus_ack,
    output logic [31:0]      bus_rdata,
    output logic             bus_err,
    output logic             tx_valid,
    output logic [7:0]       tx_byte,
    input  logic             tx_empty,
    input  logic             tx_full,
    output logic             rx_pop,
    input  logic [RX_DW-1:0] rx_data,
    input  logic [CNT_W-1:0] rx_count,
    output logic             irq
);
    localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(RX_DEPTH);

    bus_state_e state_q, state_d;
    reg_sel_e   sel;
    logic [2:0] id_idx;
    logic [7:0] id_byte;
    logic       accept;
    logic       wr_hit, rd_hit;

    logic [LOWPWR_W-1:0]  lowpwr_q;
    logic [DIV_INT_W-1:0] div_int_q;
    logic [DIV_FRC_W-1:0] div_frac_q;
    logic [LINE_W-1:0]    line_q;
    logic [CTRL_W-1:0]    ctrl_q;
    logic [LEVEL_W-1:0]   level_q;
    logic [IRQ_W-1:0]     mask_q;
    logic [DMA_W-1:0]     dma_q;

    logic [IRQ_W-1:0] raw_st, masked_st;
    logic [7:0]       flag_word;
    logic [31:0]      rd_mux;

    uart_addr_decode u_dec (
        .addr   (bus_addr),
        .sel    (sel),
        .id_idx (id_idx)
    );

    uart_id_rom #(.VARIANT(ID_VARIANT)) u_idrom (
        .idx     (id_idx),
        .id_byte (id_byte)
    );

    assign accept = (state_q == ST_IDLE) && bus_req;
    assign wr_hit = accept && bus_we;
    assign rd_hit = accept && !bus_we;

    uart_irq_ctrl #(.CNT_W(CNT_W), .RX_TRIG(RX_TRIG)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_set   (wr_hit && (sel == SEL_DATA)),
        .clr_we   (wr_hit && (sel == SEL_CLEAR)),
        .clr_bits (bus_wdata[IRQ_W-1:0]),
        .rx_count (rx_count),
        .mask     (mask_q),
        .raw      (raw_st),
        .masked   (masked_st),
        .irq      (irq)
    );

    assign rx_pop = rd_hit && (sel == SEL_DATA);

    assign flag_word = {tx_empty, (rx_count >= FULL_LVL), tx_full,
                        (rx_count == '0), 4'b0000};

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: accept (IDLE->RESP), release (RESP->IDLE)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (bus_req) state_d = ST_RESP;
            ST_RESP: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        rd_mux = '0;
        unique case (sel)
            SEL_DATA:     rd_mux = 32'(rx_data);
            SEL_FLAG:     rd_mux = 32'(flag_word);
            SEL_LOWPWR:   rd_mux = 32'(lowpwr_q);
            SEL_DIV_INT:  rd_mux = 32'(div_int_q);
            SEL_DIV_FRAC: rd_mux = 32'(div_frac_q);
            SEL_LINE:     rd_mux = 32'(line_q);
            SEL_CTRL:     rd_mux = 32'(ctrl_q);
            SEL_LEVEL:    rd_mux = 32'(level_q);
            SEL_MASK:     rd_mux = 32'(mask_q);
            SEL_RAW:      rd_mux = 32'(raw_st);
            SEL_MASKED:   rd_mux = 32'(masked_st);
            SEL_DMA:      rd_mux = 32'(dma_q);
            SEL_IDTAB:    rd_mux = 32'(id_byte);
            SEL_ZERO, SEL_CLEAR, SEL_BAD: rd_mux = '0;
            default:      rd_mux = '0;
        endcase
    end

    // Configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lowpwr_q   <= '0;
            div_int_q  <= '0;
            div_frac_q <= '0;
            line_q     <= '0;
            ctrl_q     <= CTRL_RST;
            level_q    <= LEVEL_RST;
            mask_q     <= '0;
            dma_q      <= '0;
        end else if (wr_hit) begin
            unique case (sel)
                SEL_LOWPWR:   lowpwr_q   <= bus_wdata[LOWPWR_W-1:0];
                SEL_DIV_INT:  div_int_q  <= bus_wdata[DIV_INT_W-1:0];
                SEL_DIV_FRAC: div_frac_q <= bus_wdata[DIV_FRC_W-1:0];
                SEL_LINE:     line_q     <= bus_wdata[LINE_W-1:0];
                SEL_CTRL:     ctrl_q     <= bus_wdata[CTRL_W-1:0];
                SEL_LEVEL:    level_q    <= bus_wdata[LEVEL_W-1:0];
                SEL_MASK:     mask_q     <= bus_wdata[IRQ_W-1:0];
                SEL_DMA:      dma_q      <= bus_wdata[DMA_W-1:0];
                default:      ;
            endcase
        end
    end

    // Registered outputs of the access machine
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_ack   <= 1'b0;
            bus_rdata <= '0;
            bus_err   <= 1'b0;
            tx_valid  <= 1'b0;
            tx_byte   <= '0;
        end else begin
            bus_ack  <= accept;
            bus_err  <= accept && (sel == SEL_BAD);
            tx_valid <= wr_hit && (sel == SEL_DATA);
            if (wr_hit && (sel == SEL_DATA)) tx_byte <= bus_wdata[7:0];
            if (rd_hit) bus_rdata <= rd_mux;
        end
    end
endmodule

// File: rtl/uart_regif_chk.sv
module uart_regif_chk (
    input logic clk,
    input logic rst_n,
    input logic bus_req,
    input logic bus_ack,
    input logic bus_err,
    input logic tx_valid,
    input logic rx_pop
);
    p_ack_follows_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> bus_ack);
    p_ack_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |=> !bus_ack);
    p_err_with_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> bus_ack);
    p_tx_with_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> bus_ack);
    p_pop_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop |=> !rx_pop);
    p_pop_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop |-> (bus_req && !bus_ack));
endmodule

bind uart_regif uart_regif_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_req  (bus_req),
    .bus_ack  (bus_ack),
    .bus_err  (bus_err),
    .tx_valid (tx_valid),
    .rx_pop   (rx_pop)
);

// File: tb/uart_regif_tb_top.sv
`timescale 1ns/1ps
module uart_regif_tb_top;
    localparam int DEPTH = 16;
    localparam int DW    = 12;
    localparam int CW    = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_req = 1'b0, bus_we = 1'b0;
    logic [11:0]   bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic          bus_ack, bus_err, tx_valid, rx_pop, irq;
    logic [31:0]   bus_rdata;
    logic [7:0]    tx_byte;
    logic          tx_empty = 1'b1, tx_full = 1'b0;
    logic [DW-1:0] rx_data;
    logic [CW-1:0] rx_count;

    int checks = 0, errors = 0, tx_pulses = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    uart_regif #(.ID_VARIANT(0), .RX_DEPTH(DEPTH), .RX_DW(DW), .RX_TRIG(1)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
        .bus_rdata(bus_rdata), .bus_err(bus_err), .tx_valid(tx_valid),
        .tx_byte(tx_byte), .tx_empty(tx_empty), .tx_full(tx_full),
        .rx_pop(rx_pop), .rx_data(rx_data), .rx_count(rx_count), .irq(irq)
    );

    // Receive FIFO model
    logic [DW-1:0] fmem [DEPTH];
    logic [3:0]    rd_ptr;
    logic          push_en = 1'b0;
    logic [DW-1:0] push_val = '0;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr   <= '0;
            rx_count <= '0;
        end else begin
            if (push_en) fmem[4'(rd_ptr + 4'(rx_count))] <= push_val;
            if (rx_pop && rx_count != 0) rd_ptr <= rd_ptr + 4'd1;
            rx_count <= rx_count + CW'(push_en) - CW'(rx_pop && rx_count != 0);
        end
    end
    assign rx_data = fmem[rd_ptr];

    always_ff @(posedge clk) if (tx_valid) tx_pulses <= tx_pulses + 1;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    logic [31:0] r_data;
    logic        r_ack, r_err, r_tx;
    logic [7:0]  r_byte;

    task automatic access(input logic we, input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0;
        r_ack = bus_ack; r_data = bus_rdata; r_err = bus_err;
        r_tx = tx_valid; r_byte = tx_byte;
    endtask

    task automatic push(input logic [DW-1:0] v);
        @(negedge clk);
        push_en = 1'b1; push_val = v;
        @(negedge clk);
        push_en = 1'b0;
    endtask

    // {we, addr, wdata, expected read}
    localparam logic [76:0] VEC [24] = '{
        {1'b0, 12'h030, 32'h0, 32'h300},       // R2 control reset
        {1'b0, 12'h034, 32'h0, 32'h12},        // R2 level reset
        {1'b0, 12'h018, 32'h0, 32'h90},        // R3 flags reset
        {1'b0, 12'h038, 32'h0, 32'h0},         // R2 mask reset
        {1'b0, 12'h004, 32'h0, 32'h0},         // R9 index 1
        {1'b1, 12'h024, 32'hFFFFFFFF, 32'h0},
        {1'b0, 12'h024, 32'h0, 32'hFFFF},      // R2 16 bits
        {1'b1, 12'h028, 32'hFFFFFFFF, 32'h0},
        {1'b0, 12'h028, 32'h0, 32'h3F},        // R2 6 bits
        {1'b1, 12'h02C, 32'h1AB, 32'h0},
        {1'b0, 12'h02C, 32'h0, 32'hAB},        // R2 8 bits
        {1'b1, 12'h020, 32'h1FF, 32'h0},
        {1'b0, 12'h020, 32'h0, 32'hFF},        // R2 8 bits
        {1'b1, 12'h048, 32'hF, 32'h0},
        {1'b0, 12'h048, 32'h0, 32'h7},         // R2 3 bits
        {1'b1, 12'h018, 32'h0, 32'h0},
        {1'b0, 12'h018, 32'h0, 32'h90},        // R3 write ignored
        {1'b0, 12'hFE0, 32'h0, 32'h11},        // R8
        {1'b0, 12'hFE4, 32'h0, 32'h10},        // R8
        {1'b0, 12'hFE8, 32'h0, 32'h14},        // R8
        {1'b0, 12'hFFC, 32'h0, 32'hB1},        // R8
        {1'b1, 12'h030, 32'h1234, 32'h0},
        {1'b0, 12'h030, 32'h0, 32'h1234},      // R2
        {1'b0, 12'h044, 32'h0, 32'h0}          // clear word reads zero
    };

    initial begin : wdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset ack", 32'(bus_ack), 0);
        chk("R7 reset irq", 32'(irq), 0);
        chk("R4 reset tx_valid", 32'(tx_valid), 0);
        chk("R5 reset rx_pop", 32'(rx_pop), 0);

        foreach (VEC[i]) begin
            access(VEC[i][76], VEC[i][75:64], VEC[i][63:32]);
            chk($sformatf("R1 table[%0d] ack", i), 32'(r_ack), 1);
            if (!VEC[i][76])
                chk($sformatf("R2|R3|R8 table[%0d]", i), r_data, VEC[i][31:0]);
        end

        // R4 transmit
        access(1'b1, 12'h000, 32'h1A5);
        chk("R4 tx_valid", 32'(r_tx), 1);
        chk("R4 tx_byte", 32'(r_byte), 32'hA5);
        access(1'b0, 12'h03C, 0);
        chk("R4 raw tx bit", r_data, 32'h20);
        chk("R7 irq masked off", 32'(irq), 0);
        access(1'b1, 12'h038, 32'h20);
        @(negedge clk);
        chk("R7 irq after mask", 32'(irq), 1);
        access(1'b0, 12'h040, 0);
        chk("R7 masked status", r_data, 32'h20);
        access(1'b1, 12'h044, 32'h20);
        @(negedge clk);
        chk("R7 irq after clear", 32'(irq), 0);
        access(1'b0, 12'h03C, 0);
        chk("R7 raw after clear", r_data, 32'h0);

        // R1 request held across ack: one side effect only
        @(negedge clk);
        tx_pulses = 0;
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = 12'h000; bus_wdata = 32'h33;
        repeat (2) @(negedge clk);
        bus_req = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 held request pulses", 32'(tx_pulses), 1);
        access(1'b1, 12'h044, 32'h7FF);

        // R6 receive level crossing
        access(1'b1, 12'h038, 32'h10);
        push(12'h041);
        @(negedge clk);
        chk("R6 irq on rise", 32'(irq), 1);
        access(1'b0, 12'h03C, 0);
        chk("R6 raw rx bit", r_data, 32'h10);
        access(1'b0, 12'h018, 0);
        chk("R3 flags one entry", r_data, 32'h80);
        access(1'b0, 12'h000, 0);
        chk("R5 pop data", r_data, 32'h041);
        @(negedge clk);
        chk("R6 irq after drain", 32'(irq), 0);
        access(1'b0, 12'h03C, 0);
        chk("R6 raw after drain", r_data, 32'h0);

        // R5 wide value
        push(12'h400);
        access(1'b0, 12'h000, 0);
        chk("R5 wide value", r_data, 32'h400);

        // R3 full, R6 only one set on the way up
        for (int k = 0; k < DEPTH; k++) push(DW'(k + 1));
        access(1'b1, 12'h044, 32'h10);
        @(negedge clk);
        chk("R6 no re-set above trigger", 32'(irq), 0);
        access(1'b0, 12'h018, 0);
        chk("R3 flags full", r_data, 32'hC0);
        for (int k = 0; k < DEPTH; k++) begin
            access(1'b0, 12'h000, 0);
            if (k == 0 || k == DEPTH - 1)
                chk("R5 drain order", r_data, 32'(k + 1));
        end
        access(1'b0, 12'h018, 0);
        chk("R3 flags drained", r_data, 32'h90);

        // R9 undefined offsets
        access(1'b0, 12'h008, 0);
        chk("R9 bad read data", r_data, 0);
        chk("R9 bad read err", 32'(r_err), 1);
        access(1'b1, 12'h050, 32'hFFFF);
        chk("R9 bad write err", 32'(r_err), 1);
        access(1'b0, 12'h030, 0);
        chk("R9 control untouched", r_data, 32'h1234);
        chk("R9 no err on good read", 32'(r_err), 0);
        access(1'b0, 12'h004, 0);
        chk("R9 index 1 no err", 32'(r_err), 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule